// File: doc/BRIEF.md
# Multi-Stage Pattern Trigger Sequencer

This block works like the trigger circuit of a logic analyzer. Every clock cycle it compares a vector of sense inputs against the match groups of the stage it is currently in. It steps through up to eight programmed stages, and when a stage's fire action is taken it emits a one-cycle trigger pulse for a cross-trigger network and latches an interrupt.

Each stage has four prioritised match groups. A group holds a signal mask, an action (stay, advance, jump, fire), a jump target and a flag that gates it on the stage counter. The stage counter either counts occurrences of the counted group or counts elapsed cycles in the stage, and it is compared against a programmed threshold. Software configures the stages through a simple word write/read port while the block is disarmed. It then raises the arm input to start detection.

Top module: `trig_seq_top`

## Requirements
- R1: After reset the current stage is 0, `trig_o` and `irq_o` are low, and every configuration word reads back as zero.
- R2: A group matches when its mask is nonzero and every sense bit selected by the mask is 1. A group with an all-zero mask never matches. A group word is mask in bits [7:0], action in [9:8], target in [12:10] and counted flag in [13]. It is addressed as {stage[2:0], group[2:0]} with group 0..3.
- R3: When several groups of the current stage match in one cycle, the lowest-numbered group alone decides the action.
- R4: Action 2'b00 keeps the stage. Action 2'b01 moves to stage+1, and stage 7 wraps to stage 0.
- R5: Action 2'b10 moves to the group's target stage.
- R6: Action 2'b11 returns to stage 0, drives `trig_o` high for the one cycle after the deciding edge, and sets `irq_o` on the same edge.
- R7: The stage word at sub-address 4 holds threshold [7:0] and mode [8]. In event mode (mode 0), a counted group's condition is met only on its threshold-th winning occurrence. Earlier occurrences only count.
- R8: In cycle mode (mode 1) the counter advances every armed cycle in the stage. A counted group's condition is met only when the counter equals the threshold: the counter is 0 at the first edge evaluated in the stage.
- R9: The counter returns to zero whenever any condition is met, so it restarts on every stage change.
- R10: `irq_o` stays high until a write to the status sub-address 5 with bit 0 set. A write with bit 0 clear leaves it high. This write is accepted while armed.
- R11: While `arm_i` is low the stage is forced to 0, the sense inputs are ignored and no trigger or interrupt is raised.
- R12: Configuration writes made while `arm_i` is high are dropped. Readback and detection behaviour are unchanged.
- R13: Status reads return the interrupt level in bit 0 and the current stage in bits [6:4]. Configuration words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Detection enable |
| sense_i | input | NUM_SENSE | Observed signals |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | STG_W+3 | {stage, sub-address} |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_rdata_o | output | DATA_W | Read data for cfg_addr_i |
| trig_o | output | 1 | One-cycle trigger pulse |
| irq_o | output | 1 | Interrupt level |

## Verification
The hardest situation to reach is a stale counter value surviving a stage change. To expose it, a stage is programmed to fire on its second counted occurrence. The bench feeds one occurrence, leaves the stage and comes back through a second stage's jump, and then checks that a single further occurrence does not fire. The cycle-timer window is also narrow. The bench holds the counted pattern steadily after entering the stage and checks the trigger at each of the following edges, so an off-by-one in either direction is caught.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_NEXT = 2'b01,
      ACT_JUMP = 2'b10,
      ACT_FIRE = 2'b11
   } act_e;

   localparam int          SUB_W      = 3;
   localparam logic [2:0]  SUB_STAGE  = 3'd4;
   localparam logic [2:0]  SUB_STATUS = 3'd5;
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
   import trig_seq_pkg::*;
#(
   parameter int NUM_SENSE  = 8,
   parameter int NUM_STAGES = 8,
   parameter int NUM_PRIO   = 4,
   parameter int CNT_W      = 8,
   parameter int DATA_W     = 32,
   parameter int STG_W      = 3,
   parameter int ADDR_W     = STG_W + SUB_W
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  arm,
   input  logic                                  wr_en,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic [DATA_W-1:0]                     wdata,
   input  logic [STG_W-1:0]                      cur_stage,
   input  logic                                  irq_lvl,
   output logic [DATA_W-1:0]                     rdata,
   output logic [NUM_PRIO-1:0][NUM_SENSE-1:0]    sel_mask,
   output logic [NUM_PRIO-1:0][1:0]              sel_act,
   output logic [NUM_PRIO-1:0][STG_W-1:0]        sel_tgt,
   output logic [NUM_PRIO-1:0]                   sel_cnt,
   output logic [CNT_W-1:0]                      sel_thr,
   output logic                                  sel_cyc,
   output logic                                  irq_clr
);
   localparam int GRP_W  = NUM_SENSE + 2 + STG_W + 1;
   localparam int ACT_LO = NUM_SENSE;
   localparam int TGT_LO = NUM_SENSE + 2;
   localparam int CNT_B  = NUM_SENSE + 2 + STG_W;

   logic [GRP_W-1:0] grp_q [NUM_STAGES][NUM_PRIO];
   logic [CNT_W:0]   stg_q [NUM_STAGES];

   logic [SUB_W-1:0] sub;
   logic [STG_W-1:0] stg_a;
   logic             stg_ok;
   logic             wr_ok;

   assign sub    = addr[SUB_W-1:0];
   assign stg_a  = addr[ADDR_W-1:SUB_W];
   assign stg_ok = int'(stg_a) < NUM_STAGES;
   assign wr_ok  = wr_en && !arm && stg_ok;
   assign irq_clr = wr_en && (sub == SUB_STATUS) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_STAGES; s++) begin
            stg_q[s] <= '0;
            for (int g = 0; g < NUM_PRIO; g++) grp_q[s][g] <= '0;
         end
      end else if (wr_ok) begin
         for (int s = 0; s < NUM_STAGES; s++) begin
            if (int'(stg_a) == s && sub == SUB_STAGE) stg_q[s] <= wdata[CNT_W:0];
            for (int g = 0; g < NUM_PRIO; g++)
               if (int'(stg_a) == s && int'(sub) == g) grp_q[s][g] <= wdata[GRP_W-1:0];
         end
      end
   end

   for (genvar g = 0; g < NUM_PRIO; g++) begin : g_sel
      assign sel_mask[g] = grp_q[cur_stage][g][NUM_SENSE-1:0];
      assign sel_act[g]  = grp_q[cur_stage][g][ACT_LO +: 2];
      assign sel_tgt[g]  = grp_q[cur_stage][g][TGT_LO +: STG_W];
      assign sel_cnt[g]  = grp_q[cur_stage][g][CNT_B];
   end
   assign sel_thr = stg_q[cur_stage][CNT_W-1:0];
   assign sel_cyc = stg_q[cur_stage][CNT_W];

   always_comb begin
      rdata = '0;
      if (sub == SUB_STATUS) begin
         rdata[0]          = irq_lvl;
         rdata[4 +: STG_W] = cur_stage;
      end else if (stg_ok && sub == SUB_STAGE) begin
         rdata[CNT_W:0] = stg_q[stg_a];
      end else if (stg_ok && int'(sub) < NUM_PRIO) begin
         rdata[GRP_W-1:0] = grp_q[stg_a][sub[$clog2(NUM_PRIO)-1:0]];
      end
   end
endmodule

// File: rtl/trig_seq_match.sv
module trig_seq_match #(
   parameter int NUM_SENSE = 8,
   parameter int NUM_PRIO  = 4,
   parameter int PRIO_W    = $clog2(NUM_PRIO)
) (
   input  logic [NUM_SENSE-1:0]               sense,
   input  logic [NUM_PRIO-1:0][NUM_SENSE-1:0] mask,
   output logic                               any_hit,
   output logic [PRIO_W-1:0]                  win
);
   logic [NUM_PRIO-1:0] grp_hit;

   for (genvar g = 0; g < NUM_PRIO; g++) begin : g_cmp
      assign grp_hit[g] = (|mask[g]) && ((sense & mask[g]) == mask[g]);
   end

   assign any_hit = |grp_hit;

   always_comb begin
      win = '0;
      for (int g = NUM_PRIO - 1; g >= 0; g--)
         if (grp_hit[g]) win = PRIO_W'(g);
   end
endmodule

// File: rtl/trig_seq_core.sv
module trig_seq_core
   import trig_seq_pkg::*;
#(
   parameter int NUM_STAGES = 8,
   parameter int STG_W      = 3,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             hit,
   input  logic [1:0]       act,
   input  logic [STG_W-1:0] tgt,
   input  logic             counted,
   input  logic [CNT_W-1:0] thr,
   input  logic             cyc_mode,
   input  logic             irq_clr,
   output logic [STG_W-1:0] stage_q,
   output logic             trig_q,
   output logic             irq_q
);
   localparam logic [STG_W-1:0] LAST = STG_W'(NUM_STAGES - 1);

   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
   logic [STG_W-1:0] stage_d;
   logic             met, fire;

   assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

   always_comb begin
      met = 1'b0;
      if (hit) begin
         if (!counted)      met = 1'b1;
         else if (cyc_mode) met = (cnt_q == thr);
         else               met = ({1'b0, cnt_q} + 1'b1) == {1'b0, thr};
      end

      if (met)                     cnt_d = '0;
      else if (cyc_mode)           cnt_d = cnt_inc;
      else if (hit && counted)     cnt_d = cnt_inc;
      else                         cnt_d = cnt_q;

      stage_d = stage_q;
      fire    = 1'b0;
      if (met) begin
         case (act_e'(act))
            ACT_NEXT: stage_d = (stage_q == LAST) ? '0 : stage_q + 1'b1;
            ACT_JUMP: stage_d = (int'(tgt) < NUM_STAGES) ? tgt : '0;
            ACT_FIRE: begin
               stage_d = '0;
               fire    = 1'b1;
            end
            default:  stage_d = stage_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cnt_q   <= '0;
         trig_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (!arm) begin
            stage_q <= '0;
            cnt_q   <= '0;
            trig_q  <= 1'b0;
         end else begin
            stage_q <= stage_d;
            cnt_q   <= cnt_d;
            trig_q  <= fire;
         end
         if (arm && fire)  irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
   import trig_seq_pkg::*;
#(
   parameter int NUM_SENSE  = 8,
   parameter int NUM_STAGES = 8,
   parameter int NUM_PRIO   = 4,
   parameter int CNT_W      = 8,
   parameter int DATA_W     = 32,
   parameter int STG_W      = $clog2(NUM_STAGES),
   parameter int ADDR_W     = STG_W + SUB_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm_i,
   input  logic [NUM_SENSE-1:0] sense_i,
   input  logic                 cfg_we_i,
   input  logic [ADDR_W-1:0]    cfg_addr_i,
   input  logic [DATA_W-1:0]    cfg_wdata_i,
   output logic [DATA_W-1:0]    cfg_rdata_o,
   output logic                 trig_o,
   output logic                 irq_o
);
   localparam int PRIO_W = $clog2(NUM_PRIO);

   if (NUM_PRIO < 2 || NUM_PRIO > 4) begin : g_bad_prio
      $error("NUM_PRIO must lie in 2..4");
   end
   if (NUM_STAGES < 2) begin : g_bad_stages
      $error("NUM_STAGES must be at least 2");
   end
   if (NUM_SENSE + 3 + STG_W > DATA_W || CNT_W + 1 > DATA_W || STG_W + 4 > DATA_W) begin : g_bad_width
      $error("DATA_W too narrow for configuration words");
   end

   logic [NUM_PRIO-1:0][NUM_SENSE-1:0] sel_mask;
   logic [NUM_PRIO-1:0][1:0]           sel_act;
   logic [NUM_PRIO-1:0][STG_W-1:0]     sel_tgt;
   logic [NUM_PRIO-1:0]                sel_cnt;
   logic [CNT_W-1:0]                   sel_thr;
   logic                               sel_cyc;
   logic                               irq_clr_w;
   logic [STG_W-1:0]                   stage_w;
   logic                               any_hit;
   logic [PRIO_W-1:0]                  win;

   trig_seq_cfg #(
      .NUM_SENSE(NUM_SENSE), .NUM_STAGES(NUM_STAGES), .NUM_PRIO(NUM_PRIO),
      .CNT_W(CNT_W), .DATA_W(DATA_W), .STG_W(STG_W), .ADDR_W(ADDR_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .arm(arm_i), .wr_en(cfg_we_i),
      .addr(cfg_addr_i), .wdata(cfg_wdata_i), .cur_stage(stage_w),
      .irq_lvl(irq_o), .rdata(cfg_rdata_o), .sel_mask(sel_mask),
      .sel_act(sel_act), .sel_tgt(sel_tgt), .sel_cnt(sel_cnt),
      .sel_thr(sel_thr), .sel_cyc(sel_cyc), .irq_clr(irq_clr_w)
   );

   trig_seq_match #(
      .NUM_SENSE(NUM_SENSE), .NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)
   ) match_i (
      .sense(sense_i), .mask(sel_mask), .any_hit(any_hit), .win(win)
   );

   trig_seq_core #(
      .NUM_STAGES(NUM_STAGES), .STG_W(STG_W), .CNT_W(CNT_W)
   ) core_i (
      .clk(clk), .rst_n(rst_n), .arm(arm_i), .hit(any_hit),
      .act(sel_act[win]), .tgt(sel_tgt[win]), .counted(sel_cnt[win]),
      .thr(sel_thr), .cyc_mode(sel_cyc), .irq_clr(irq_clr_w),
      .stage_q(stage_w), .trig_q(trig_o), .irq_q(irq_o)
   );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
   parameter int NUM_STAGES = 8,
   parameter int STG_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             trig,
   input logic             irq,
   input logic [STG_W-1:0] stage,
   input logic             irq_clr
);
   assert_fire_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> irq);

   assert_fire_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (stage == '0));

   assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> trig);

   assert_idle_when_disarmed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (stage == '0) && !trig);

   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   assert_stage_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(stage) < NUM_STAGES);
endmodule

bind trig_seq_top trig_seq_chk #(
   .NUM_STAGES(NUM_STAGES), .STG_W(STG_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .arm(arm_i), .trig(trig_o), .irq(irq_o),
   .stage(stage_w), .irq_clr(irq_clr_w)
);

// File: tb/trig_seq_top_tb_top.sv
module trig_seq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic [7:0]  sense = '0;
   logic        we = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        trig, irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   trig_seq_top dut_i (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .sense_i(sense),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .cfg_rdata_o(rdata), .trig_o(trig), .irq_o(irq)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         summary();
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] grp(logic [7:0] m, logic [1:0] a, logic [2:0] t, logic c);
      return {18'd0, c, t, a, m};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; arm = 1'b0; sense = '0; we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(int stg, int sub, logic [31:0] d);
      addr = 6'((stg << 3) | sub); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int stg, int sub, output logic [31:0] d);
      addr = 6'((stg << 3) | sub);
      #1 d = rdata;
   endtask

   task automatic cur_stage(output int s);
      logic [31:0] d;
      rd(0, 5, d);
      s = int'(d[6:4]);
   endtask

   task automatic step(logic [7:0] s);
      sense = s;
      @(negedge clk);
   endtask

   task automatic t_reset_R1();
      logic [31:0] d;
      int s;
      do_reset();
      cur_stage(s);
      chk("R1 stage", s, 0);
      chk("R1 trig", int'(trig), 0);
      chk("R1 irq", int'(irq), 0);
      rd(3, 2, d);
      chk("R1 cfg zero", int'(d), 0);
   endtask

   task automatic t_readback_R13();
      logic [31:0] d;
      do_reset();
      wr(2, 1, grp(8'hA5, 2'b10, 3'd6, 1'b1));
      wr(2, 4, 32'h1C3);
      rd(2, 1, d);
      chk("R13 group readback", int'(d), int'(grp(8'hA5, 2'b10, 3'd6, 1'b1)));
      rd(2, 4, d);
      chk("R13 stage readback", int'(d), 32'h1C3);
   endtask

   task automatic t_stay_next_R4();
      int s;
      do_reset();
      wr(0, 0, grp(8'h01, 2'b01, 3'd0, 1'b0));
      wr(1, 0, grp(8'h02, 2'b00, 3'd0, 1'b0));
      arm = 1'b1;
      step(8'h01);
      cur_stage(s); chk("R4 advance", s, 1);
      step(8'h02);
      cur_stage(s); chk("R4 stay", s, 1);
      chk("R4 no trig", int'(trig), 0);
   endtask

   task automatic t_jump_R5();
      int s;
      do_reset();
      wr(0, 0, grp(8'h04, 2'b10, 3'd7, 1'b0));
      wr(7, 0, grp(8'h10, 2'b01, 3'd0, 1'b0));
      arm = 1'b1;
      step(8'h04);
      cur_stage(s); chk("R5 jump to 7", s, 7);
      step(8'h10);
      cur_stage(s); chk("R4 wrap 7 to 0", s, 0);
   endtask

   task automatic t_priority_R3();
      int s;
      do_reset();
      wr(0, 1, grp(8'h03, 2'b10, 3'd3, 1'b0));
      wr(0, 2, grp(8'h01, 2'b10, 3'd6, 1'b0));
      arm = 1'b1;
      step(8'h02);
      cur_stage(s); chk("R2 partial mask no match", s, 0);
      step(8'hFF);
      cur_stage(s); chk("R3 lowest group wins", s, 3);
      arm = 1'b0; step(8'h00); arm = 1'b1;
      step(8'h01);
      cur_stage(s); chk("R2 single group match", s, 6);
   endtask

   task automatic t_fire_irq_R6_R10();
      int s;
      do_reset();
      wr(0, 0, grp(8'h01, 2'b01, 3'd0, 1'b0));
      wr(1, 0, grp(8'h02, 2'b11, 3'd0, 1'b0));
      arm = 1'b1;
      step(8'h01);
      chk("R6 no early trig", int'(trig), 0);
      step(8'h02);
      chk("R6 trig pulse", int'(trig), 1);
      chk("R6 irq set", int'(irq), 1);
      cur_stage(s); chk("R6 back to 0", s, 0);
      step(8'h00);
      chk("R6 pulse one cycle", int'(trig), 0);
      chk("R10 irq held", int'(irq), 1);
      wr(0, 5, 32'h0);
      chk("R10 zero write keeps irq", int'(irq), 1);
      wr(0, 5, 32'h1);
      chk("R10 w1c clears irq", int'(irq), 0);
   endtask

   task automatic t_event_count_R7();
      do_reset();
      wr(0, 0, grp(8'h01, 2'b11, 3'd0, 1'b1));
      wr(0, 4, 32'h003);
      arm = 1'b1;
      step(8'h01); chk("R7 occurrence 1", int'(trig), 0);
      step(8'h00);
      step(8'h01); chk("R7 occurrence 2", int'(trig), 0);
      step(8'h00);
      step(8'h01); chk("R7 occurrence 3 fires", int'(trig), 1);
   endtask

   task automatic t_cycle_timer_R8();
      int s;
      do_reset();
      wr(0, 0, grp(8'h01, 2'b01, 3'd0, 1'b0));
      wr(1, 0, grp(8'h02, 2'b11, 3'd0, 1'b1));
      wr(1, 4, 32'h104);
      arm = 1'b1;
      step(8'h01);
      cur_stage(s); chk("R8 entered stage 1", s, 1);
      for (int i = 0; i < 4; i++) begin
         step(8'h02);
         chk("R8 before window", int'(trig), 0);
      end
      step(8'h02);
      chk("R8 fires at threshold", int'(trig), 1);
   endtask

   task automatic t_counter_clear_R9();
      int s;
      do_reset();
      wr(0, 0, grp(8'h01, 2'b11, 3'd0, 1'b1));
      wr(0, 1, grp(8'h02, 2'b01, 3'd0, 1'b0));
      wr(0, 4, 32'h002);
      wr(1, 0, grp(8'h04, 2'b10, 3'd0, 1'b0));
      arm = 1'b1;
      step(8'h01);
      step(8'h02);
      cur_stage(s); chk("R9 left stage 0", s, 1);
      step(8'h04);
      cur_stage(s); chk("R9 back in stage 0", s, 0);
      step(8'h01); chk("R9 counter restarted", int'(trig), 0);
      step(8'h01); chk("R9 second count fires", int'(trig), 1);
   endtask

   task automatic t_disarm_R11();
      int s;
      do_reset();
      wr(0, 0, grp(8'h01, 2'b01, 3'd0, 1'b0));
      wr(1, 0, grp(8'h02, 2'b11, 3'd0, 1'b0));
      arm = 1'b1;
      step(8'h01);
      arm = 1'b0;
      step(8'h00);
      cur_stage(s); chk("R11 disarm resets stage", s, 0);
      step(8'h01);
      cur_stage(s); chk("R11 inputs ignored", s, 0);
      step(8'h02);
      chk("R11 no trig", int'(trig), 0);
      chk("R11 no irq", int'(irq), 0);
   endtask

   task automatic t_armed_write_R12();
      logic [31:0] d;
      do_reset();
      wr(0, 0, grp(8'h01, 2'b01, 3'd0, 1'b0));
      wr(1, 0, grp(8'h02, 2'b11, 3'd0, 1'b0));
      arm = 1'b1;
      wr(1, 0, 32'h0);
      rd(1, 0, d);
      chk("R12 readback unchanged", int'(d), int'(grp(8'h02, 2'b11, 3'd0, 1'b0)));
      step(8'h01);
      step(8'h02);
      chk("R12 detection unchanged", int'(trig), 1);
   endtask

   initial begin
      t_reset_R1();
      t_readback_R13();
      t_stay_next_R4();
      t_jump_R5();
      t_priority_R3();
      t_fire_irq_R6_R10();
      t_event_count_R7();
      t_cycle_timer_R8();
      t_counter_clear_R9();
      t_disarm_R11();
      t_armed_write_R12();
      summary();
   end
endmodule